// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the host-visible register file of a DMA controller with up to twelve channels. A word-wide register port (address, write enable, write data, read data) reaches a small set of global words. Each channel has a three-bit field holding its transfer mode and direction, and an interrupt enable bit. Each channel also has sticky interrupt and error flags and a live two-bit engine state. The block drives those settings to the channel engines and collects their completion and error pulses. It merges the enabled flags into one interrupt line.

Above the global words, each channel has a four-word descriptor window. The block decodes that window and forwards it to the owning engine as a one-hot select, a word index and a write strobe. Reads inside a window return the data the engine presents. When software writes a disabled mode into a channel field, the block sends a one-cycle abort pulse to that engine. Interrupt and error flags are cleared by writing ones, so software can write back a status word it has just read.

Top module: `dmac_csr`

## Requirements
- R1: Byte address 0x00 is control word A, 0x08 is the enable word, 0x0C is control word B, 0x10 is status word A and 0x18 is status word B. The words at 0x04, 0x14 and 0x1C read as zero, and writes to them change nothing.
- R2: Channel n < 8 owns bits 4n+2..4n of control word A, and channel n >= 8 owns bits 4(n-8)+2..4(n-8) of control word B. In that field, bits 1:0 are the mode (0 disabled, 1 scatter-gather, 2 one-shot) and bit 2 is the direction (1 = memory to device). Bit 3 of each nibble reads zero. ch_mode[2n+1:2n] and ch_dir[n] show the stored field.
- R3: The interrupt enable of channel n is bit n of the enable word for n < 8 and bit n+8 for n >= 8. All other bits of that word read zero.
- R4: In status word A, channel n < 8 shows its interrupt flag at bit n, its error flag at bit n+8 and its engine state at bits 17+2n:16+2n. Status word B uses the same layout for channels 8 and up, with index n-8. The state field follows eng_state live (0 idle, 1 descriptor read, 2 waiting, 3 data access).
- R5: A pulse on eng_done[n] sets the channel's interrupt flag. A pulse on eng_err[n] sets both its interrupt flag and its error flag. The flags are visible from the clock edge that samples the pulse.
- R6: Writing a status word clears each interrupt or error flag whose bit is written as one and leaves the flags written as zero unchanged.
- R7: When an event pulse and a write-one clear hit the same flag in the same cycle, the flag stays set.
- R8: irq is high exactly when at least one channel has both its interrupt flag and its enable set.
- R9: Writes to a status word leave the state fields unchanged.
- R10: A write to a control word gives a one-cycle ch_abort pulse, in the cycle after the write, on every channel of that word whose written mode is 0. Channels written with a nonzero mode, and channels of the other word, get no pulse.
- R11: Address 0x20+16n+4k (n < channel count) raises win_sel[n] alone with win_word = k, and win_we follows reg_we. A read there returns win_rdata. Addresses at or above the last window select nothing and read zero.
- R12: After reset, all control fields, enables and flags are zero, irq is low and no abort pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | AW | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address (combinational) |
| eng_state | input | 2*NCH | Live state of each channel engine, two bits per channel |
| eng_done | input | NCH | Completion pulse from each engine |
| eng_err | input | NCH | Error pulse from each engine |
| win_rdata | input | 32 | Data returned by the engine whose window is addressed |
| ch_mode | output | 2*NCH | Mode of each channel |
| ch_dir | output | NCH | Direction of each channel, 1 = memory to device |
| ch_abort | output | NCH | One-cycle abort request per channel |
| irq | output | 1 | Combined interrupt |
| win_sel | output | NCH | One-hot descriptor window select |
| win_word | output | 2 | Word index inside the selected window |
| win_we | output | 1 | Write strobe toward the selected window |

## Verification
The bench targets the split of channels across two control words and two status words. A design that put channels 8 and up at the wrong offset, or their enables at bit n instead of n+8, would show their fields in the wrong bits or gate the interrupt with the wrong channel. It writes back a status word it has read, and it writes state positions with ones. A flawed clear would drop flags that were not written or corrupt the live state. It also drives a completion pulse into the same cycle as a clear, where a design with the wrong priority would lose the event. Finally it checks that abort pulses reach only the channels written with mode 0, and that window decoding stops at the last channel.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

  localparam int WORD_W      = 32;
  localparam int GRP_CH      = 8;   // channels served by one control/status word
  localparam int MAX_CH      = 12;

  // byte offsets of the global words
  localparam int OFS_CTL_A   = 'h00;
  localparam int OFS_CTL_1   = 'h04;
  localparam int OFS_EN      = 'h08;
  localparam int OFS_CTL_B   = 'h0C;
  localparam int OFS_STS_A   = 'h10;
  localparam int OFS_STS_1   = 'h14;
  localparam int OFS_STS_B   = 'h18;
  localparam int WIN_BASE    = 'h20;
  localparam int WIN_BYTES   = 16;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SG   = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DESC = 2'd1,
    ENG_WAIT = 2'd2,
    ENG_XFER = 2'd3
  } eng_state_e;

  // channel lives in the second word of a pair
  function automatic logic in_hi(input int ch);
    return ch >= GRP_CH;
  endfunction

  // position of a channel inside its word group
  function automatic int grp_idx(input int ch);
    return ch % GRP_CH;
  endfunction

  // lsb of the 3-bit mode/direction field
  function automatic int fld_lsb(input int ch);
    return 4 * grp_idx(ch);
  endfunction

  // interrupt enable bit in the enable word
  function automatic int en_bit(input int ch);
    return in_hi(ch) ? ch + 8 : ch;
  endfunction

  // flag and state positions in a status word
  function automatic int irq_bit(input int ch);
    return grp_idx(ch);
  endfunction

  function automatic int err_bit(input int ch);
    return grp_idx(ch) + 8;
  endfunction

  function automatic int st_lsb(input int ch);
    return 16 + 2 * grp_idx(ch);
  endfunction

endpackage

// File: rtl/dmac_csr_dec.sv
module dmac_csr_dec
  import dmac_csr_pkg::*;
#(
  parameter int NCH = 12,
  parameter int AW  = 8
) (
  input  logic [AW-1:0]  addr,
  output logic           hit_ctl_a,
  output logic           hit_en,
  output logic           hit_ctl_b,
  output logic           hit_sts_a,
  output logic           hit_sts_b,
  output logic           win_any,
  output logic [NCH-1:0] win_sel,
  output logic [1:0]     win_word
);

  localparam int WIN_END = WIN_BASE + WIN_BYTES * NCH;
  localparam int IW      = AW - 4;

  logic [AW-3:0] word_addr;
  logic [AW-1:0] rel;
  logic [IW-1:0] win_idx;
  logic          in_win;

  assign word_addr = addr[AW-1:2];
  assign hit_ctl_a = word_addr == (AW-2)'(OFS_CTL_A >> 2);
  assign hit_en    = word_addr == (AW-2)'(OFS_EN    >> 2);
  assign hit_ctl_b = word_addr == (AW-2)'(OFS_CTL_B >> 2);
  assign hit_sts_a = word_addr == (AW-2)'(OFS_STS_A >> 2);
  assign hit_sts_b = word_addr == (AW-2)'(OFS_STS_B >> 2);

  assign rel     = addr - AW'(WIN_BASE);
  assign win_idx = rel[AW-1:4];
  assign in_win  = ({1'b0, addr} >= (AW+1)'(WIN_BASE)) &&
                   ({1'b0, addr} <  (AW+1)'(WIN_END));
  assign win_any  = in_win;
  assign win_word = addr[3:2];

  for (genvar g = 0; g < NCH; g++) begin : g_win
    assign win_sel[g] = in_win && (win_idx == IW'(g));
  end

endmodule

// File: rtl/dmac_csr_chan.sv
module dmac_csr_chan
  import dmac_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fld_we,
  input  logic [2:0] fld_in,
  input  logic       en_we,
  input  logic       en_in,
  input  logic       clr_irq,
  input  logic       clr_err,
  input  logic       ev_done,
  input  logic       ev_err,
  output logic [1:0] mode,
  output logic       dir,
  output logic       en,
  output logic       irq_flag,
  output logic       err_flag,
  output logic       abort
);

  logic set_irq;
  assign set_irq = ev_done | ev_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= 2'b00;
      dir      <= 1'b0;
      en       <= 1'b0;
      irq_flag <= 1'b0;
      err_flag <= 1'b0;
      abort    <= 1'b0;
    end else begin
      if (fld_we) begin
        mode <= fld_in[1:0];
        dir  <= fld_in[2];
      end
      abort <= fld_we && (mode_e'(fld_in[1:0]) == MODE_OFF);
      if (en_we) en <= en_in;
      // a new event outranks a clear arriving in the same cycle
      irq_flag <= set_irq | (irq_flag & ~clr_irq);
      err_flag <= ev_err  | (err_flag & ~clr_err);
    end
  end

endmodule

// File: rtl/dmac_csr_rmux.sv
module dmac_csr_rmux
  import dmac_csr_pkg::*;
(
  input  logic              hit_ctl_a,
  input  logic              hit_en,
  input  logic              hit_ctl_b,
  input  logic              hit_sts_a,
  input  logic              hit_sts_b,
  input  logic              win_any,
  input  logic [WORD_W-1:0] ctl_a,
  input  logic [WORD_W-1:0] en_w,
  input  logic [WORD_W-1:0] ctl_b,
  input  logic [WORD_W-1:0] sts_a,
  input  logic [WORD_W-1:0] sts_b,
  input  logic [WORD_W-1:0] win_rdata,
  output logic [WORD_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (hit_ctl_a)      rdata = ctl_a;
    else if (hit_en)    rdata = en_w;
    else if (hit_ctl_b) rdata = ctl_b;
    else if (hit_sts_a) rdata = sts_a;
    else if (hit_sts_b) rdata = sts_b;
    else if (win_any)   rdata = win_rdata;
  end

endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_csr_pkg::*;
#(
  parameter int NCH = 12,   // at most MAX_CH
  parameter int AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_we,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [2*NCH-1:0]  eng_state,
  input  logic [NCH-1:0]    eng_done,
  input  logic [NCH-1:0]    eng_err,
  input  logic [WORD_W-1:0] win_rdata,
  output logic [2*NCH-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_dir,
  output logic [NCH-1:0]    ch_abort,
  output logic              irq,
  output logic [NCH-1:0]    win_sel,
  output logic [1:0]        win_word,
  output logic              win_we
);

  logic hit_ctl_a, hit_en, hit_ctl_b, hit_sts_a, hit_sts_b, win_any;

  // named per-channel events, also watched by the checker
  logic [NCH-1:0] fld_we;
  logic [NCH-1:0] clr_irq;
  logic [NCH-1:0] clr_err;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] irq_flag;
  logic [NCH-1:0] err_flag;

  logic [WORD_W-1:0] ctl_a, en_w, ctl_b, sts_a, sts_b;

  dmac_csr_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .addr      (reg_addr),
    .hit_ctl_a (hit_ctl_a),
    .hit_en    (hit_en),
    .hit_ctl_b (hit_ctl_b),
    .hit_sts_a (hit_sts_a),
    .hit_sts_b (hit_sts_b),
    .win_any   (win_any),
    .win_sel   (win_sel),
    .win_word  (win_word)
  );

  assign win_we = reg_we & win_any;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit HI  = in_hi(g);
    localparam int FL  = fld_lsb(g);
    localparam int EB  = en_bit(g);
    localparam int IB  = irq_bit(g);
    localparam int EEB = err_bit(g);

    logic sts_hit;
    assign sts_hit    = HI ? hit_sts_b : hit_sts_a;
    assign fld_we[g]  = reg_we & (HI ? hit_ctl_b : hit_ctl_a);
    assign clr_irq[g] = reg_we & sts_hit & reg_wdata[IB];
    assign clr_err[g] = reg_we & sts_hit & reg_wdata[EEB];

    dmac_csr_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .fld_we   (fld_we[g]),
      .fld_in   (reg_wdata[FL +: 3]),
      .en_we    (reg_we & hit_en),
      .en_in    (reg_wdata[EB]),
      .clr_irq  (clr_irq[g]),
      .clr_err  (clr_err[g]),
      .ev_done  (eng_done[g]),
      .ev_err   (eng_err[g]),
      .mode     (ch_mode[2*g +: 2]),
      .dir      (ch_dir[g]),
      .en       (en_q[g]),
      .irq_flag (irq_flag[g]),
      .err_flag (err_flag[g]),
      .abort    (ch_abort[g])
    );
  end

  // assemble the host-visible words
  always_comb begin
    ctl_a = '0;
    ctl_b = '0;
    en_w  = '0;
    sts_a = '0;
    sts_b = '0;
    for (int i = 0; i < NCH; i++) begin
      en_w[en_bit(i)] = en_q[i];
      if (in_hi(i)) begin
        ctl_b[fld_lsb(i) +: 3]  = {ch_dir[i], ch_mode[2*i +: 2]};
        sts_b[irq_bit(i)]       = irq_flag[i];
        sts_b[err_bit(i)]       = err_flag[i];
        sts_b[st_lsb(i) +: 2]   = eng_state[2*i +: 2];
      end else begin
        ctl_a[fld_lsb(i) +: 3]  = {ch_dir[i], ch_mode[2*i +: 2]};
        sts_a[irq_bit(i)]       = irq_flag[i];
        sts_a[err_bit(i)]       = err_flag[i];
        sts_a[st_lsb(i) +: 2]   = eng_state[2*i +: 2];
      end
    end
  end

  assign irq = |(irq_flag & en_q);

  dmac_csr_rmux u_rmux (
    .hit_ctl_a (hit_ctl_a),
    .hit_en    (hit_en),
    .hit_ctl_b (hit_ctl_b),
    .hit_sts_a (hit_sts_a),
    .hit_sts_b (hit_sts_b),
    .win_any   (win_any),
    .ctl_a     (ctl_a),
    .en_w      (en_w),
    .ctl_b     (ctl_b),
    .sts_a     (sts_a),
    .sts_b     (sts_b),
    .win_rdata (win_rdata),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/dmac_csr_chk.sv
module dmac_csr_chk #(
  parameter int NCH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [NCH-1:0]   eng_done,
  input logic [NCH-1:0]   eng_err,
  input logic [NCH-1:0]   clr_irq,
  input logic [NCH-1:0]   irq_flag,
  input logic [NCH-1:0]   err_flag,
  input logic [NCH-1:0]   en_q,
  input logic [2*NCH-1:0] ch_mode,
  input logic [NCH-1:0]   ch_abort,
  input logic             irq,
  input logic [NCH-1:0]   win_sel,
  input logic             win_we
);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[g] || eng_err[g]) |=> irq_flag[g]);

    assert_err_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err[g] |=> err_flag[g]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_irq[g] && !eng_done[g] && !eng_err[g]) |=> !irq_flag[g]);

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_irq[g] && eng_done[g]) |=> irq_flag[g]);

    assert_abort_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ch_abort[g] |-> (ch_mode[2*g +: 2] == 2'b00));

    assert_abort_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ch_abort[g] |=> (!ch_abort[g] || $past(reg_we)));
  end

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  assert_win_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));

  assert_win_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_we |-> (reg_we && (win_sel != '0)));

endmodule

bind dmac_csr dmac_csr_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .eng_done (eng_done),
  .eng_err  (eng_err),
  .clr_irq  (clr_irq),
  .irq_flag (irq_flag),
  .err_flag (err_flag),
  .en_q     (en_q),
  .ch_mode  (ch_mode),
  .ch_abort (ch_abort),
  .irq      (irq),
  .win_sel  (win_sel),
  .win_we   (win_we)
);

// File: tb/dmac_csr_test.sv
`timescale 1ns/1ps
module dmac_csr_test;

  localparam int NCH = 12;
  localparam int AW  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic              reg_we = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [2*NCH-1:0]  eng_state = '0;
  logic [NCH-1:0]    eng_done = '0;
  logic [NCH-1:0]    eng_err = '0;
  logic [31:0]       win_rdata = 32'hDEADBEEF;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH-1:0]    ch_dir;
  logic [NCH-1:0]    ch_abort;
  logic              irq;
  logic [NCH-1:0]    win_sel;
  logic [1:0]        win_word;
  logic              win_we;

  always #5 clk = ~clk;

  dmac_csr #(.NCH(NCH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_state(eng_state),
    .eng_done(eng_done), .eng_err(eng_err), .win_rdata(win_rdata),
    .ch_mode(ch_mode), .ch_dir(ch_dir), .ch_abort(ch_abort), .irq(irq),
    .win_sel(win_sel), .win_word(win_word), .win_we(win_we)
  );

  // scoreboard item kinds
  localparam int K_RD = 0, K_IRQ = 1, K_ABT = 2, K_SEL = 3, K_WORD = 4,
                 K_WE = 5, K_MODE = 6, K_DIR = 7;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  // monitor: compare every expectation one step after the sampling edge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = reg_rdata;
        K_IRQ:   act = 32'(irq);
        K_ABT:   act = 32'(ch_abort);
        K_SEL:   act = 32'(win_sel);
        K_WORD:  act = 32'(win_word);
        K_WE:    act = 32'(win_we);
        K_MODE:  act = 32'(ch_mode);
        default: act = 32'(ch_dir);
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [31:0] exp_abort, input string tag);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    push(K_ABT, exp_abort, tag);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    push(K_RD, exp, tag);
    @(negedge clk);
  endtask

  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    push(kind, exp, tag);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NCH-1:0] d, input logic [NCH-1:0] e);
    eng_done = d; eng_err = e;
    @(negedge clk);
    eng_done = '0; eng_err = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(8'h00, 32'h0, "R12 control A after reset");
    rd(8'h08, 32'h0, "R12 enables after reset");
    rd(8'h10, 32'h0, "R12 status A after reset");
    chk(K_IRQ, 32'h0, "R12 irq after reset");
    chk(K_ABT, 32'h0, "R12 no abort after reset");

    // control word A fields, abort only on ch3 (mode 0)
    wr(8'h00, 32'hF6A54321, 32'h008, "R10 abort from control A write");
    rd(8'h00, 32'h76254321, "R2 control A readback");
    chk(K_MODE, 32'h0000E939, "R2 mode outputs");
    chk(K_DIR, 32'h000000D8, "R2 direction outputs");
    chk(K_ABT, 32'h0, "R10 abort lasts one cycle");

    // control word B, channels 8..11
    wr(8'h0C, 32'h0000A0C1, 32'h600, "R10 abort from control B write");
    rd(8'h0C, 32'h00002041, "R2 control B readback");
    chk(K_DIR, 32'h000002D8, "R2 direction of ch9");
    wr(8'h00, 32'h0, 32'h0FF, "R10 abort on all low channels");
    wr(8'h00, 32'h11111111, 32'h0, "R10 no abort for nonzero modes");
    wr(8'h00, 32'h0, 32'h0FF, "R10 abort on all low channels again");

    // enable word
    wr(8'h08, 32'hFFFFFFFF, 32'h0, "R3 enable write no abort");
    rd(8'h08, 32'h000F00FF, "R3 enable layout");

    // unused words
    wr(8'h04, 32'hFFFFFFFF, 32'h0, "R1 write to 0x04 no abort");
    rd(8'h04, 32'h0, "R1 word 0x04 reads zero");
    wr(8'h14, 32'hFFFFFFFF, 32'h0, "R1 write to 0x14 no abort");
    rd(8'h14, 32'h0, "R1 word 0x14 reads zero");
    rd(8'h1C, 32'h0, "R1 word 0x1C reads zero");
    rd(8'h00, 32'h0, "R1 control A untouched by unused writes");
    rd(8'h10, 32'h0, "R1 status A untouched by unused writes");

    // live state
    eng_state = '0;
    eng_state[1:0]   = 2'd3;
    eng_state[3:2]   = 2'd1;
    eng_state[15:14] = 2'd2;
    eng_state[17:16] = 2'd2;
    eng_state[23:22] = 2'd3;
    rd(8'h10, 32'h80070000, "R4 status A state fields");
    rd(8'h18, 32'h00C20000, "R4 status B state fields");

    // events
    pulse(12'h004, 12'h200);
    rd(8'h10, 32'h80070004, "R5 done sets ch2 flag");
    rd(8'h18, 32'h00C20202, "R5 error sets ch9 flags");
    chk(K_IRQ, 32'h1, "R8 irq with enabled flags");

    // state read-only, zero bits leave flags
    wr(8'h10, 32'hFFFF0000, 32'h0, "R9 write state positions");
    rd(8'h10, 32'h80070004, "R9 state and flags unchanged");

    // write back what was read
    wr(8'h18, 32'h00C20202, 32'h0, "R6 write back status B");
    rd(8'h18, 32'h00C20000, "R6 status B flags cleared");
    chk(K_IRQ, 32'h1, "R6 ch2 flag still raises irq");
    wr(8'h10, 32'h00000004, 32'h0, "R6 clear ch2");
    rd(8'h10, 32'h80070000, "R6 status A flag cleared");
    chk(K_IRQ, 32'h0, "R8 irq low with no flags");

    // enable gating
    wr(8'h08, 32'h0, 32'h0, "R3 disable all");
    pulse(12'h020, 12'h000);
    rd(8'h10, 32'h80070020, "R5 flag set while disabled");
    chk(K_IRQ, 32'h0, "R8 irq masked by enable");
    wr(8'h08, 32'h00000020, 32'h0, "R3 enable ch5");
    chk(K_IRQ, 32'h1, "R8 irq after enabling ch5");
    wr(8'h08, 32'h00020000, 32'h0, "R3 enable ch9 at bit 17");
    chk(K_IRQ, 32'h0, "R3 ch5 disabled, ch9 idle");
    pulse(12'h000, 12'h200);
    chk(K_IRQ, 32'h1, "R3 ch9 enable at bit 17 gates irq");
    rd(8'h18, 32'h00C20202, "R5 ch9 error again");

    // clear and event in the same cycle
    eng_done = 12'h020;
    wr(8'h10, 32'h00000020, 32'h0, "R7 clear with coincident event");
    eng_done = '0;
    rd(8'h10, 32'h80070020, "R7 event wins over clear");
    wr(8'h10, 32'h00000020, 32'h0, "R6 clear without event");
    rd(8'h10, 32'h80070000, "R6 flag cleared");

    // descriptor windows
    reg_addr = 8'h58; reg_we = 1'b1; reg_wdata = 32'h12345678;
    push(K_SEL, 32'h008, "R11 window ch3 select");
    push(K_WORD, 32'h2, "R11 window word index");
    push(K_WE, 32'h1, "R11 window write strobe");
    push(K_ABT, 32'h0, "R11 window write no abort");
    @(negedge clk);
    reg_we = 1'b0;
    rd(8'h00, 32'h0, "R11 window write leaves control A");
    reg_addr = 8'hDC;
    push(K_SEL, 32'h800, "R11 last window select");
    push(K_WE, 32'h0, "R11 no strobe on read");
    push(K_RD, 32'hDEADBEEF, "R11 window read data");
    @(negedge clk);
    reg_addr = 8'hE0;
    push(K_SEL, 32'h0, "R11 beyond last window");
    push(K_RD, 32'h0, "R11 beyond last window reads zero");
    @(negedge clk);

    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule